// File: doc/BRIEF.md
# Periodic Interval Timer with Missed-Tick Catch-Up

This block keeps a free-running cycle counter and raises a periodic interrupt every PERIOD cycles. It does this by comparing the low 32 bits of the counter with a hardware-managed compare value. Software sets the period and enables the timer. It then only has to acknowledge each interrupt, because the block itself schedules the next deadline.

When an acknowledge arrives, possibly long after the deadline, a small state machine adds the period one step per clock. It does this until the deadline is again within one period of the count value sampled at acknowledge, and it reports how many periods it added. It then skips over further deadlines that have already passed, using the live count, so that interrupts stay on the original period grid. If the resulting deadline lies within a guard window of the current count, it adds one more period before arming the compare. All distance tests use unsigned modular subtraction (deadline minus count), so a deadline that has already passed looks like a very large distance.

States: IDLE (stopped) goes to START once the timer is enabled with a nonzero period. START sets the first deadline and goes to ARMED. ARMED goes to PENDING on a compare match. PENDING goes to ACCOUNT on acknowledge. ACCOUNT loops until the accounting condition or the iteration limit is met, then goes to ADVANCE. ADVANCE loops while the deadline is behind, applies the guard and goes back to ARMED. Whenever the timer is disabled or the period is zero, every state falls back to IDLE.

Top module: `itick_timer`

## Requirements
- R1: The counter is cleared by reset and rises by exactly one every clock. Its low and high words read at addresses 3 and 4. Writes to those addresses have no effect on it.
- R2: After reset, CTRL (address 0), PERIOD (address 1) and TICKS (address 2) all read 0 and `irq` is low.
- R3: With PERIOD (address 1) nonzero, the first deadline is the count two cycles after the enabling CTRL write, plus PERIOD. A match with the low 32 bits of the counter sets pending. When each interrupt is acknowledged in the following cycle, successive interrupts are exactly PERIOD cycles apart.
- R4: `irq` equals pending AND the CTRL interrupt-allow bit. CTRL bits are: bit0 enable, bit1 interrupt allow, bit2 pending (read-only), bit3 busy (read-only), bit4 overflow (write 1 to clear).
- R5: An acknowledge while pending clears pending. An acknowledge at any other time has no effect.
- R6: On acknowledge, the count is sampled. The deadline then advances by PERIOD at least once, and keeps advancing while (deadline - sample) mod 2^CNT_W exceeds PERIOD. The number of additions is latched into TICKS (address 2), which clears when it is read.
- R7: After accounting, the deadline keeps advancing by PERIOD while (deadline - live count) mod 2^CNT_W exceeds PERIOD, so deadlines already passed are skipped.
- R8: If the remaining distance to the deadline is GUARD cycles or less, one more PERIOD is added before the compare is armed.
- R9: With enable clear or PERIOD zero, the scheduler is idle, pending is clear and no interrupt is raised.
- R10: Accounting stops after 2^ITER_W additions. TICKS then reads 2^ITER_W and the overflow bit is set. If the skip loop reaches the same limit, the deadline restarts at count + PERIOD and the overflow bit is set.
- R11: Busy (CTRL bit3) is high while the deadline update runs, and any acknowledge during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears in the following cycle |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |

## Verification
The hardest situations to reach are late service: acknowledges that land just before, exactly on, or well past a later period boundary, and the case where accounting runs out of iterations. The bench holds off the acknowledge for chosen numbers of cycles after the interrupt. These are picked so that the deadline lands inside the guard window, lands exactly on a boundary that the skip loop must then pass, or covers several periods. It measures the spacing to the next interrupt in cycles. For the iteration limit, a very short period and a reduced limit are used, so that accounting is cut off and the skip loop has to close a large gap against the live count.

// File: rtl/itick_pkg.sv
package itick_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ARMED,
        ST_PENDING,
        ST_ACCOUNT,
        ST_ADVANCE
    } sched_state_t;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] A_PERIOD = 3'd1;
    localparam logic [REG_AW-1:0] A_TICKS  = 3'd2;
    localparam logic [REG_AW-1:0] A_CNT_LO = 3'd3;
    localparam logic [REG_AW-1:0] A_CNT_HI = 3'd4;

    localparam int B_EN   = 0;
    localparam int B_ALLOW = 1;
    localparam int B_PEND = 2;
    localparam int B_BUSY = 3;
    localparam int B_OVF  = 4;

endpackage

// File: rtl/itick_counter.sv
module itick_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end

    // R1: one step per clock
    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count == $past(count) + 1'b1);

endmodule

// File: rtl/itick_sched.sv
module itick_sched
    import itick_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ITER_W = 16,
    parameter int GUARD  = 8000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [31:0]      period,
    input  logic [CNT_W-1:0] count,
    input  logic             irq_ack,
    output logic             pending,
    output logic             busy,
    output logic             done,
    output logic [ITER_W:0]  ticks,
    output logic             ovf_set
);

    localparam int unsigned CAP_I = 1 << ITER_W;
    localparam logic [ITER_W:0] CAP    = CAP_I[ITER_W:0];
    localparam logic [ITER_W:0] CAP_M1 = CAP - 1'b1;
    localparam logic [CNT_W-1:0] GUARD_X = CNT_W'(GUARD);

    sched_state_t     state_q, state_d;
    logic [CNT_W-1:0] next_q, next_d;
    logic [CNT_W-1:0] snap_q, snap_d;
    logic [31:0]      cmp_q, cmp_d;
    logic [ITER_W:0]  ticks_q, ticks_d;
    logic [ITER_W:0]  skips_q, skips_d;
    logic             pend_q, pend_d;

    logic             active;
    logic [CNT_W-1:0] period_x;
    logic [CNT_W-1:0] step_sum;
    logic [CNT_W-1:0] dist_acc;
    logic [CNT_W-1:0] dist_live;

    assign active    = enable && (period != 32'd0);
    assign period_x  = CNT_W'(period);
    assign step_sum  = next_q + period_x;
    assign dist_acc  = step_sum - snap_q;
    assign dist_live = next_q - count;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            next_q  <= '0;
            snap_q  <= '0;
            cmp_q   <= '0;
            ticks_q <= '0;
            skips_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            next_q  <= next_d;
            snap_q  <= snap_d;
            cmp_q   <= cmp_d;
            ticks_q <= ticks_d;
            skips_q <= skips_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        state_d = state_q;
        next_d  = next_q;
        snap_d  = snap_q;
        cmp_d   = cmp_q;
        ticks_d = ticks_q;
        skips_d = skips_q;
        pend_d  = pend_q;
        done    = 1'b0;
        ovf_set = 1'b0;
        if (!active) begin
            state_d = ST_IDLE;
            pend_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_START;
                ST_START: begin
                    next_d  = count + period_x;
                    cmp_d   = next_d[31:0];
                    state_d = ST_ARMED;
                end
                ST_ARMED: begin
                    if (count[31:0] == cmp_q) begin
                        pend_d  = 1'b1;
                        state_d = ST_PENDING;
                    end
                end
                ST_PENDING: begin
                    if (irq_ack) begin
                        pend_d  = 1'b0;
                        snap_d  = count;
                        ticks_d = '0;
                        state_d = ST_ACCOUNT;
                    end
                end
                ST_ACCOUNT: begin
                    next_d  = step_sum;
                    ticks_d = ticks_q + 1'b1;
                    if (dist_acc <= period_x) begin
                        skips_d = '0;
                        state_d = ST_ADVANCE;
                    end else if (ticks_d == CAP) begin
                        ovf_set = 1'b1;
                        skips_d = '0;
                        state_d = ST_ADVANCE;
                    end
                end
                ST_ADVANCE: begin
                    if (dist_live > period_x) begin
                        if (skips_q == CAP_M1) begin
                            next_d  = count + period_x;
                            skips_d = '0;
                            ovf_set = 1'b1;
                        end else begin
                            next_d  = step_sum;
                            skips_d = skips_q + 1'b1;
                        end
                    end else begin
                        if (dist_live <= GUARD_X) next_d = step_sum;
                        cmp_d   = next_d[31:0];
                        done    = 1'b1;
                        state_d = ST_ARMED;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign pending = pend_q;
    assign busy    = (state_q == ST_ACCOUNT) || (state_q == ST_ADVANCE);
    assign ticks   = ticks_q;

    // R9: disabled or zero period forces idle
    p_idle_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!enable || period == 32'd0) |=> state_q == ST_IDLE);

    // R6: at least one period is always accounted
    p_ticks_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> ticks != '0);

    // R10: accounting never runs past its limit
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_ACCOUNT |-> ticks_q < CAP);

    // R11: no pending interrupt while the update runs
    p_busy_clear_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !pending);

    // R5: pending holds until acknowledged
    p_pending_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (pending && !irq_ack && active) |=> pending);

endmodule

// File: rtl/itick_regs.sv
module itick_regs
    import itick_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ITER_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              pending,
    input  logic              busy,
    input  logic              done,
    input  logic [ITER_W:0]   ticks_in,
    input  logic              ovf_set,
    output logic              enable,
    output logic              allow,
    output logic [31:0]       period,
    output logic [31:0]       rdata
);

    logic [ITER_W:0] ticks_r;
    logic            ovf_r;
    logic [31:0]     cnt_hi;
    logic [31:0]     rd_val;

    generate
        if (CNT_W > 32) begin : g_wide
            logic [63:0] cnt_ext;
            assign cnt_ext = 64'(count);
            assign cnt_hi  = cnt_ext[63:32];
        end else begin : g_narrow
            assign cnt_hi = 32'd0;
        end
    endgenerate

    always_comb begin
        rd_val = 32'd0;
        unique case (addr)
            A_CTRL: begin
                rd_val[B_EN]    = enable;
                rd_val[B_ALLOW] = allow;
                rd_val[B_PEND]  = pending;
                rd_val[B_BUSY]  = busy;
                rd_val[B_OVF]   = ovf_r;
            end
            A_PERIOD: rd_val = period;
            A_TICKS:  rd_val = 32'(ticks_r);
            A_CNT_LO: rd_val = count[31:0];
            A_CNT_HI: rd_val = cnt_hi;
            default:  rd_val = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable  <= 1'b0;
            allow   <= 1'b0;
            period  <= 32'd0;
            ovf_r   <= 1'b0;
            ticks_r <= '0;
            rdata   <= 32'd0;
        end else begin
            if (wr && addr == A_CTRL) begin
                enable <= wdata[B_EN];
                allow  <= wdata[B_ALLOW];
                if (wdata[B_OVF]) ovf_r <= 1'b0;
            end
            if (wr && addr == A_PERIOD) period <= wdata;
            if (ovf_set) ovf_r <= 1'b1;
            if (rd && addr == A_TICKS) ticks_r <= '0;
            if (done) ticks_r <= ticks_in;
            if (rd) rdata <= rd_val;
        end
    end

    // R6: tick count clears on read
    p_ticks_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_TICKS && !done) |=> ticks_r == '0);

endmodule

// File: rtl/itick_timer.sv
module itick_timer
    import itick_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ITER_W = 16,
    parameter int GUARD  = 8000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic        irq_ack
);

    logic [CNT_W-1:0] count;
    logic             enable, allow, pending, busy, done, ovf_set;
    logic [31:0]      period;
    logic [ITER_W:0]  ticks;

    itick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    itick_sched #(.CNT_W(CNT_W), .ITER_W(ITER_W), .GUARD(GUARD)) u_sched (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .period  (period),
        .count   (count),
        .irq_ack (irq_ack),
        .pending (pending),
        .busy    (busy),
        .done    (done),
        .ticks   (ticks),
        .ovf_set (ovf_set)
    );

    itick_regs #(.CNT_W(CNT_W), .ITER_W(ITER_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .count    (count),
        .pending  (pending),
        .busy     (busy),
        .done     (done),
        .ticks_in (ticks),
        .ovf_set  (ovf_set),
        .enable   (enable),
        .allow    (allow),
        .period   (period),
        .rdata    (reg_rdata)
    );

    assign irq = pending & allow;

    // R4: no interrupt while disallowed
    p_irq_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !allow |-> !irq);

endmodule

// File: tb/itick_timer_test.sv
module itick_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int PER = 1000;
    localparam int NROW = 5;
    localparam int ROW_WAIT [0:NROW-1] = '{0, 849, 999, 2099, 3499};
    localparam int ROW_TICK [0:NROW-1] = '{1, 1, 1, 3, 4};
    localparam int ROW_GAP  [0:NROW-1] = '{1000, 2000, 2000, 3000, 5000};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        irq_ack = 1'b0;

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;

    itick_timer #(.CNT_W(64), .ITER_W(8), .GUARD(800)) uut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .irq_ack   (irq_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (irq !== 1'b1);
    endtask

    task automatic ack_pulse(input int n);
        irq_ack = 1'b1;
        repeat (n) @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog R3: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d, v1;
        int r, r2, k, highs;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        check("R2 irq", irq, 0);
        reg_read(3'd0, d); check("R2 ctrl", d, 0);
        reg_read(3'd1, d); check("R2 period", d, 0);
        reg_read(3'd2, d); check("R2 ticks", d, 0);
        reg_read(3'd4, d); check("R1 count high", d, 0);

        // R1 counter steps and ignores writes
        reg_read(3'd3, v1);
        reg_write(3'd3, 32'hFFFF);
        reg_read(3'd3, d);
        check("R1 count step", d - v1, 2);

        // R3 first deadline
        reg_write(3'd1, PER);
        reg_write(3'd0, 32'h3);
        k = cyc;
        wait_irq();
        r = cyc;
        check("R3 first interrupt delay", r - k, PER + 2);

        // vector walk: late acknowledges (R5 R6 R7 R8 R11)
        for (int i = 0; i < NROW; i++) begin
            repeat (ROW_WAIT[i]) @(negedge clk);
            ack_pulse(3);
            repeat (20) @(negedge clk);
            reg_read(3'd2, d); check("R6 ticks", d, ROW_TICK[i]);
            reg_read(3'd2, d); check("R6 ticks clear on read", d, 0);
            ack_pulse(1);
            wait_irq();
            r2 = cyc;
            check("R3/R7/R8 interval", r2 - r, ROW_GAP[i]);
            r = r2;
        end

        // R4 masking
        reg_write(3'd0, 32'h1);
        check("R4 irq masked", irq, 0);
        reg_read(3'd0, d); check("R4 ctrl pending visible", d, 5);
        reg_write(3'd0, 32'h3);
        check("R4 irq unmasked", irq, 1);
        ack_pulse(3);

        // R9 zero period
        reg_write(3'd1, 32'd0);
        highs = 0;
        for (int j = 0; j < 3000; j++) begin
            @(negedge clk);
            if (irq) highs++;
        end
        check("R9 no interrupt", highs, 0);
        reg_read(3'd0, d); check("R9 ctrl idle", d, 3);

        // R10 iteration limit, R11 busy
        reg_write(3'd0, 32'h0);
        reg_write(3'd1, 32'd4);
        reg_write(3'd0, 32'h3);
        wait_irq();
        repeat (1299) @(negedge clk);
        ack_pulse(3);
        reg_read(3'd0, d); check("R5/R11 busy set pending clear", d & 32'hC, 8);
        repeat (700) @(negedge clk);
        reg_read(3'd2, d); check("R10 ticks at limit", d, 256);
        reg_read(3'd0, d); check("R10 overflow set", (d >> 4) & 1, 1);
        reg_write(3'd0, 32'h13);
        reg_read(3'd0, d); check("R10 overflow cleared", (d >> 4) & 1, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule